// File: doc/BRIEF.md
# Multi-Domain Clock Enable Controller

This block produces single-cycle enable strobes for six clock domains of a processor subsystem. Everything runs on one fast generator clock. A slower reference clock is presented as a one-cycle tick on that clock. Downstream logic uses each strobe as a clock enable. The block never gates or muxes a real clock.

Software programs the block through a small synchronous register port with three registers:

- A control register holds two power-of-two divider fields and the timer source select.
- An idle register holds per-domain idle requests.
- An enable register holds per-domain enable bits.

Each domain is built in its own way:

- The core and peripheral domains divide the generator clock independently.
- One peripheral domain follows the reference tick.
- The watchdog domain divides the reference tick by 14.
- The timer domain follows either the generator clock or the reference tick.
- The GPIO domain runs at the full generator rate.

A global idle input stops the domains that are idle-capable, provided their own idle request is set. A watchdog mode input locks the watchdog strobe on.

Top module: `clkgen_ctrl`

## Requirements
- R1: The core strobe fires once every 1, 2, 4 or 8 generator cycles, selected by control bits [1:0] with 00=/1, 01=/2, 10=/4, 11=/8.
- R2: The peripheral strobe divides independently of the core, selected by control bits [3:2] with the same encoding, and is gated by enable bit [0].
- R3: A divider setting written mid-period takes effect only after the current period ends, so the period in progress keeps its old length.
- R4: A modulo-14 counter advances only on reference ticks and wraps from 13 to 0. The watchdog strobe can fire only on the tick that wraps it, so any 56 ticks yield exactly 4 watchdog strobes.
- R5: The watchdog strobe is suppressed when enable bit [2] is clear, or when idle bit [1] and global idle are both set. While the watchdog mode input is high, it runs regardless of these bits.
- R6: Control bit [4] selects the timer source: 1 selects the reference tick, 0 selects every generator cycle. The timer strobe stops when enable bit [3] is clear, or when idle bit [2] and global idle are both set.
- R7: The reference-derived peripheral strobe equals the reference tick while enable bit [1] is set, and is otherwise low.
- R8: The GPIO strobe is high every generator cycle while enable bit [4] is set, whatever the state of global idle.
- R9: The core strobe stops only when idle bit [0] and global idle are both set. The peripheral strobe ignores global idle.
- R10: After reset, both dividers are /1, enable register = 0x1F, idle register = 0x00, and control register = 0x10 (timer source is the reference tick).
- R11: The register port writes on the clock when the write enable is high, using address 0 = control, 1 = idle and 2 = enable. Read data is registered one cycle after the address. Unused bits read as zero. Address 3 reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Generator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle reference tick, synchronous to clk_i |
| all_idle_i | input | 1 | Global idle request |
| wdog_mode_i | input | 1 | Watchdog mode; locks the watchdog strobe on |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data |
| core_en_o | output | 1 | Core domain strobe |
| per_en_o | output | 1 | Peripheral domain strobe |
| refper_en_o | output | 1 | Reference-derived peripheral strobe |
| wdog_en_o | output | 1 | Watchdog domain strobe |
| tim_en_o | output | 1 | Timer domain strobe |
| gpio_en_o | output | 1 | GPIO domain strobe |

## Verification
The hardest case to reach is a divider rewrite that lands in the middle of a long period. It only shows up if the write arrives after the strobe but before the terminal count. The bench first sets the core divider to /8 and waits for a core strobe. It then writes /2 on the next cycle and counts cycles to the following strobes, expecting a gap of 8 and then a gap of 2. The watchdog lock is reached by clearing the watchdog enable and raising idle while watchdog mode is high. The bench then issues a fixed number of ticks, so the phase of the counter does not affect the expected strobe count.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int DIV_SEL_W  = 2;
  localparam int REG_W      = 16;
  localparam int ADDR_W     = 2;
  localparam int WDOG_RATIO = 14;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_IDLE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_ENAB = 2'd2;

  typedef logic [DIV_SEL_W-1:0] div_sel_t;

  typedef struct packed {
    logic     tim_src_ref;
    div_sel_t per_div;
    div_sel_t core_div;
  } ctrl_t;

  typedef struct packed {
    logic tim_idle;
    logic wdog_idle;
    logic core_idle;
  } idle_t;

  typedef struct packed {
    logic gpio_on;
    logic tim_on;
    logic wdog_on;
    logic refper_on;
    logic per_on;
  } enab_t;

  localparam ctrl_t CTRL_RST = '{tim_src_ref: 1'b1, per_div: '0, core_div: '0};
  localparam idle_t IDLE_RST = '0;
  localparam enab_t ENAB_RST = '1;
endpackage

// File: rtl/clkgen_pow2_div.sv
module clkgen_pow2_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic [SEL_W-1:0] cur_q, cur_d;
  logic             tc;

  always_comb begin
    lim   = CNT_W'((1 << cur_q) - 1);
    tc    = (cnt_q == lim);
    cnt_d = tc ? '0 : cnt_q + 1'b1;
    cur_d = tc ? sel_i : cur_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cur_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cur_q <= cur_d;
    end
  end

  assign tick_o = tc;

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(cur_q)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(cnt_q) && cnt_q != '0 |-> cnt_q == $past(cnt_q) + 1'b1); // R1
endmodule

// File: rtl/clkgen_ref_div.sv
module clkgen_ref_div #(
  parameter int RATIO = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  output logic pulse_o
);
  localparam int CW = $clog2(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  always_comb begin
    wrap  = ref_tick_i && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (ref_tick_i) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign pulse_o = wrap;

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> cnt_q == '0); // R4
  AST_TICK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_tick_i |=> $stable(cnt_q)); // R4
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R4
endmodule

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output ctrl_t             ctrl_o,
  output idle_t             idle_o,
  output enab_t             enab_o
);
  localparam int CTRL_W = $bits(ctrl_t);
  localparam int IDLE_W = $bits(idle_t);
  localparam int ENAB_W = $bits(enab_t);

  ctrl_t ctrl_q, ctrl_d;
  idle_t idle_q, idle_d;
  enab_t enab_q, enab_d;
  logic [REG_W-1:0] rd_q, rd_d;
  logic unused_wbits;

  assign unused_wbits = ^wdata_i[REG_W-1:CTRL_W];

  always_comb begin
    ctrl_d = ctrl_q;
    idle_d = idle_q;
    enab_d = enab_q;
    if (we_i) begin
      unique case (addr_i)
        ADDR_CTRL: ctrl_d = ctrl_t'(wdata_i[CTRL_W-1:0]);
        ADDR_IDLE: idle_d = idle_t'(wdata_i[IDLE_W-1:0]);
        ADDR_ENAB: enab_d = enab_t'(wdata_i[ENAB_W-1:0]);
        default: ;
      endcase
    end
    unique case (addr_i)
      ADDR_CTRL: rd_d = REG_W'(ctrl_q);
      ADDR_IDLE: rd_d = REG_W'(idle_q);
      ADDR_ENAB: rd_d = REG_W'(enab_q);
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      idle_q <= IDLE_RST;
      enab_q <= ENAB_RST;
      rd_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      idle_q <= idle_d;
      enab_q <= enab_d;
      rd_q   <= rd_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign idle_o  = idle_q;
  assign enab_o  = enab_q;
  assign rdata_o = rd_q;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(addr_i) == 2'd3 |-> rdata_o == '0); // R11
endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              all_idle_i,
  input  logic              wdog_mode_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              core_en_o,
  output logic              per_en_o,
  output logic              refper_en_o,
  output logic              wdog_en_o,
  output logic              tim_en_o,
  output logic              gpio_en_o
);
  ctrl_t ctrl;
  idle_t idle;
  enab_t enab;
  logic  core_tick, per_tick, wdog_tick, tim_tick;
  logic  core_run, wdog_run, tim_run;

  clkgen_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl),
    .idle_o  (idle),
    .enab_o  (enab)
  );

  clkgen_pow2_div #(.SEL_W(DIV_SEL_W)) u_core_div (
    .clk_i (clk_i), .rst_ni (rst_ni), .sel_i (ctrl.core_div), .tick_o (core_tick)
  );

  clkgen_pow2_div #(.SEL_W(DIV_SEL_W)) u_per_div (
    .clk_i (clk_i), .rst_ni (rst_ni), .sel_i (ctrl.per_div), .tick_o (per_tick)
  );

  clkgen_ref_div #(.RATIO(WDOG_RATIO)) u_wdog_div (
    .clk_i (clk_i), .rst_ni (rst_ni), .ref_tick_i (ref_tick_i), .pulse_o (wdog_tick)
  );

  always_comb begin
    core_run = !(idle.core_idle && all_idle_i);
    wdog_run = wdog_mode_i || (enab.wdog_on && !(idle.wdog_idle && all_idle_i));
    tim_run  = enab.tim_on && !(idle.tim_idle && all_idle_i);
    tim_tick = ctrl.tim_src_ref ? ref_tick_i : 1'b1;
  end

  assign core_en_o   = core_tick && core_run;
  assign per_en_o    = per_tick && enab.per_on;
  assign refper_en_o = ref_tick_i && enab.refper_on;
  assign wdog_en_o   = wdog_tick && wdog_run;
  assign tim_en_o    = tim_tick && tim_run;
  assign gpio_en_o   = enab.gpio_on;

  AST_WDOG_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_mode_i && wdog_tick |-> wdog_en_o); // R5
  AST_CORE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_idle_i && idle.core_idle |-> !core_en_o); // R9
  AST_REFPER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refper_en_o |-> ref_tick_i); // R7
  AST_WDOG_ONLY_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_en_o |-> ref_tick_i); // R4
endmodule

// File: tb/clkgen_ctrl_bench.sv
module clkgen_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_tick_i = 1'b0;
  logic        all_idle_i = 1'b0;
  logic        wdog_mode_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [15:0] reg_wdata_i = 16'h0;
  logic [15:0] reg_rdata_o;
  logic core_en_o, per_en_o, refper_en_o, wdog_en_o, tim_en_o, gpio_en_o;

  int total = 0;
  int bad   = 0;
  int n_core, n_per, n_ref, n_wdog, n_tim, n_gpio;

  always #10 clk_i = ~clk_i;

  clkgen_ctrl u_clkgen_ctrl (
    .clk_i, .rst_ni, .ref_tick_i, .all_idle_i, .wdog_mode_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .core_en_o, .per_en_o, .refper_en_o, .wdog_en_o, .tim_en_o, .gpio_en_o
  );

  task automatic chk(input string req, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk_i);
    reg_addr_i = a;
    @(negedge clk_i);
    v = int'(reg_rdata_o);
  endtask

  // tick_per = 0: no reference ticks; otherwise one tick every tick_per cycles
  task automatic run(input int ncyc, input int tick_per);
    n_core = 0; n_per = 0; n_ref = 0; n_wdog = 0; n_tim = 0; n_gpio = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk_i);
      ref_tick_i = (tick_per != 0) && (i % tick_per == 0);
      #1;
      n_core += int'(core_en_o); n_per += int'(per_en_o);
      n_ref  += int'(refper_en_o); n_wdog += int'(wdog_en_o);
      n_tim  += int'(tim_en_o); n_gpio += int'(gpio_en_o);
    end
    @(negedge clk_i);
    ref_tick_i = 1'b0;
  endtask

  task automatic t_reset;
    int v;
    rd(2'd0, v); chk("R10 ctrl reset", v, 16'h0010);
    rd(2'd1, v); chk("R10 idle reset", v, 0);
    rd(2'd2, v); chk("R10 enab reset", v, 16'h001F);
    run(8, 0);   chk("R10 core /1 after reset", n_core, 8);
    chk("R10 per /1 after reset", n_per, 8);
  endtask

  task automatic t_core_div;
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, 16'(s));
      run(20, 0);
      run(32, 0);
      chk($sformatf("R1 core sel=%0d", s), n_core, 32 >> s);
    end
  endtask

  task automatic t_per_div;
    wr(2'd0, 16'h000D); // core /2, per /8
    run(20, 0); run(32, 0);
    chk("R2 per /8", n_per, 4);
    chk("R2 core /2 alongside", n_core, 16);
    wr(2'd2, 16'h001E); // per disabled
    run(32, 0);
    chk("R2 per disabled", n_per, 0);
    wr(2'd2, 16'h001F);
  endtask

  task automatic t_switch;
    int first, second, seen;
    wr(2'd0, 16'h0003); // core /8
    run(20, 0);
    do begin
      @(negedge clk_i); #1;
    end while (!core_en_o);
    first = 0; second = 0; seen = 0;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk_i);
      if (i == 1) begin
        reg_addr_i = 2'd0; reg_wdata_i = 16'h0001; reg_we_i = 1'b1; // /2
      end else reg_we_i = 1'b0;
      #1;
      if (core_en_o) begin
        if (seen == 0) first = i;
        else if (seen == 1) second = i;
        seen++;
      end
    end
    chk("R3 old period kept", first, 8);
    chk("R3 new period applied", second - first, 2);
  endtask

  task automatic t_wdog;
    run(168, 3); chk("R4 56 ticks give 4 wdog strobes", n_wdog, 4);
    run(60, 0);  chk("R4 no ticks no strobes", n_wdog, 0);
    wr(2'd2, 16'h001B); // wdog enable off
    run(168, 3); chk("R5 wdog disabled", n_wdog, 0);
    wdog_mode_i = 1'b1;
    run(168, 3); chk("R5 wdog mode overrides enable", n_wdog, 4);
    wdog_mode_i = 1'b0;
    wr(2'd2, 16'h001F);
    wr(2'd1, 16'h0002); // wdog idle
    run(168, 3); chk("R5 idle bit without global idle", n_wdog, 4);
    all_idle_i = 1'b1;
    run(168, 3); chk("R5 idle + global idle stops", n_wdog, 0);
    wdog_mode_i = 1'b1;
    run(168, 3); chk("R5 wdog mode overrides idle", n_wdog, 4);
    wdog_mode_i = 1'b0; all_idle_i = 1'b0;
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_timer;
    wr(2'd0, 16'h0010); // ref source
    run(30, 3); chk("R6 timer from reference", n_tim, 10);
    wr(2'd0, 16'h0000); // generator source
    run(30, 3); chk("R6 timer from generator", n_tim, 30);
    wr(2'd2, 16'h0017); // timer enable off
    run(30, 0); chk("R6 timer disabled", n_tim, 0);
    wr(2'd2, 16'h001F);
    wr(2'd1, 16'h0004); all_idle_i = 1'b1;
    run(30, 0); chk("R6 timer idle + global idle", n_tim, 0);
    all_idle_i = 1'b0;
    run(30, 0); chk("R6 timer idle bit alone", n_tim, 30);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_refper;
    run(30, 3); chk("R7 refper follows ticks", n_ref, 10);
    wr(2'd2, 16'h001D);
    run(30, 3); chk("R7 refper disabled", n_ref, 0);
    wr(2'd2, 16'h001F);
  endtask

  task automatic t_gpio_idle;
    wr(2'd1, 16'h0007); all_idle_i = 1'b1;
    run(24, 0);
    chk("R8 gpio under global idle", n_gpio, 24);
    chk("R9 core stopped", n_core, 0);
    chk("R9 per ignores global idle", n_per, 24);
    all_idle_i = 1'b0;
    run(24, 0); chk("R9 core idle bit alone", n_core, 24);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h000F);
    run(24, 0); chk("R8 gpio disabled", n_gpio, 0);
    wr(2'd2, 16'h001F);
  endtask

  task automatic t_regs;
    int v;
    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R11 ctrl unused bits zero", v, 16'h001F);
    wr(2'd1, 16'hFFFF); rd(2'd1, v); chk("R11 idle unused bits zero", v, 16'h0007);
    wr(2'd3, 16'h0000); rd(2'd3, v); chk("R11 address 3 reads zero", v, 0);
    rd(2'd2, v); chk("R11 address 3 write ignored", v, 16'h001F);
    wr(2'd0, 16'h0010); wr(2'd1, 16'h0000);
    rd(2'd0, v); chk("R11 ctrl readback", v, 16'h0010);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset;
        t_core_div;
        t_per_div;
        t_switch;
        wr(2'd0, 16'h0000);
        t_wdog;
        t_timer;
        t_refper;
        t_gpio_idle;
        t_regs;
      end
      begin
        repeat (100000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule